// File: doc/BRIEF.md
# Three-Phase Sine PWM Gate Command Logic

This block turns three per-phase modulation words into six gate enables for a three-phase half-bridge power stage. A free-running carrier counter sets the switching frequency. Each leg compares the counter with a threshold scaled from its modulation word. The result is the high-side request for that leg, and its complement is the low-side request. Every leg has its own dead-time stage, so a switch turns on only after both switches of that leg have been off for a fixed number of clocks. Turning a switch off is never delayed.

Three control inputs override the carrier. They are a halt request, a brake request and a fault flag. A current-comparator input provides cycle-by-cycle limiting. When an over-current is accepted, every leg is steered to its high side for a fixed recirculation time, and then carrier-driven switching resumes. The comparator is not trusted for a short blanking window after any low-side switch turns on.

The block runs on a single 40 MHz clock. The default parameters give a 20 kHz carrier, about 1.6 µs of dead time, 0.8 µs of blanking and 24 µs of off time.

Top module: `pwmgd_top`

## Requirements
- R1: The carrier repeats every PERIOD_CYC clocks. Leg i takes its word from `modWords[i*MOD_W +: MOD_W]`, where leg 0 is bits [7:0] with the defaults. The leg's threshold is thr = (word × PERIOD_CYC) >> MOD_W. When DEAD_CYC < thr < PERIOD_CYC − DEAD_CYC, each carrier period in steady run gives thr − DEAD_CYC clocks of high-side enable and PERIOD_CYC − thr − DEAD_CYC clocks of low-side enable for that leg. Legs are independent.
- R2: The high-side and low-side enables of one leg are never asserted in the same cycle.
- R3: A gate enable rises only after both enables of its leg have been low for at least DEAD_CYC consecutive cycles.
- R4: A modulation word of 0 in run mode keeps that leg's low side on continuously and its high side off.
- R5: While `haltReq` is high, all six enables are low by the second rising edge, whatever `brakeReq` is.
- R6: With `haltReq` low, `brakeReq` high and `faultIn` low, all high-side enables are low by the second edge. All low-side enables come on once the dead time has passed.
- R7: `faultIn` high forces all six enables low by the second edge, overriding halt and brake. The fault is not latched, and normal drive resumes once `faultIn` falls.
- R8: In run mode, `ocTrip` high outside the blanking window starts a recirculation lasting OFF_CYC clocks. During it the low sides turn off and the high sides turn on after the dead time, so each high side is on for exactly OFF_CYC − DEAD_CYC clocks. Carrier switching then resumes.
- R9: `ocTrip` is ignored for BLANK_CYC clocks after any low-side enable rises.
- R10: `ocTrip` has no effect in brake mode, and the low sides stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 40 MHz nominal |
| rstN | input | 1 | Synchronous reset, active low |
| haltReq | input | 1 | High turns all gates off |
| brakeReq | input | 1 | High turns on all low sides (when not halted) |
| faultIn | input | 1 | High turns all gates off, highest priority |
| ocTrip | input | 1 | Over-current comparator output, high on trip |
| modWords | input | 3*MOD_W | Per-leg modulation words, leg 0 in the low bits |
| highGate | output | 3 | High-side gate enables, bit i = leg i |
| lowGate | output | 3 | Low-side gate enables, bit i = leg i |

## Verification
The hardest state to reach from the ports is an accepted over-current trip. The comparator has to be seen outside the blanking window, and that window reopens on every low-side turn-on. It is also hard to show that a trip arriving just after a turn-on is rejected. The stimulus drives all modulation words to zero so the low sides turn on only once, at start-up. The bench watches for that rise and places a short trip pulse inside the window. It then raises a second trip long after the window has closed. The bench counts how many cycles the high sides stay on in the recirculation and checks that count against the off time minus the dead time.

// File: rtl/pwmgd_pkg.sv
package pwmgd_pkg;
  localparam int NUM_LEGS = 3;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_BRAKE = 2'd1,
    MODE_RUN   = 2'd2
  } driveMode_t;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } legCmd_t;

  // control -> datapath strobes
  typedef struct packed {
    logic    pwmEn;     // legs follow their carrier compare
    legCmd_t forceCmd;  // command for all legs when pwmEn is low
  } ctrlStrobes_t;
endpackage

// File: rtl/pwmgd_leg.sv
module pwmgd_leg
  import pwmgd_pkg::*;
#(
  parameter int DEAD_CYC = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  legCmd_t cmd,
  output logic    hiGate,
  output logic    loGate,
  output logic    loTurnOn
);
  localparam int GAP_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

  logic [GAP_W-1:0] gapCnt, gapNext;
  logic hiNext, loNext, bothOff, gapDone;

  assign bothOff = !hiGate && !loGate;
  assign gapDone = (gapCnt == GAP_W'(DEAD_CYC - 1));

  always_comb begin
    hiNext = hiGate;
    loNext = loGate;
    unique case (cmd)
      LEG_HIGH: begin
        loNext = 1'b0;
        if (bothOff && gapDone) hiNext = 1'b1;
      end
      LEG_LOW: begin
        hiNext = 1'b0;
        if (bothOff && gapDone) loNext = 1'b1;
      end
      default: begin
        hiNext = 1'b0;
        loNext = 1'b0;
      end
    endcase
    if (!bothOff)     gapNext = '0;
    else if (gapDone) gapNext = gapCnt;
    else              gapNext = gapCnt + 1'b1;
  end

  assign loTurnOn = loNext && !loGate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiGate <= 1'b0;
      loGate <= 1'b0;
      gapCnt <= '0;
    end else begin
      hiGate <= hiNext;
      loGate <= loNext;
      gapCnt <= gapNext;
    end
  end
endmodule

// File: rtl/pwmgd_datapath.sv
module pwmgd_datapath
  import pwmgd_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int MOD_W      = 8,
  parameter int DEAD_CYC   = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic [NUM_LEGS*MOD_W-1:0] modWords,
  output logic [NUM_LEGS-1:0]       highGate,
  output logic [NUM_LEGS-1:0]       lowGate,
  output logic                      loTurnOn
);
  localparam int CNT_W  = $clog2(PERIOD_CYC);
  localparam int PROD_W = CNT_W + MOD_W;

  logic [CNT_W-1:0]    carrierCnt;
  logic [NUM_LEGS-1:0] legTurnOn;

  always_ff @(posedge clk) begin
    if (!rstN)                                          carrierCnt <= '0;
    else if (carrierCnt == CNT_W'(PERIOD_CYC - 1))      carrierCnt <= '0;
    else                                                carrierCnt <= carrierCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    logic [PROD_W-1:0] scaled;
    logic [CNT_W-1:0]  thr;
    logic              rawHi;
    legCmd_t           legCmd;

    assign scaled = PROD_W'(modWords[g*MOD_W +: MOD_W]) * PROD_W'(PERIOD_CYC);
    assign thr    = CNT_W'(scaled >> MOD_W);

    always_ff @(posedge clk) begin
      if (!rstN) rawHi <= 1'b0;
      else       rawHi <= (carrierCnt < thr);
    end

    assign legCmd = strobes.pwmEn ? (rawHi ? LEG_HIGH : LEG_LOW) : strobes.forceCmd;

    pwmgd_leg #(.DEAD_CYC(DEAD_CYC)) uLeg (
      .clk     (clk),
      .rstN    (rstN),
      .cmd     (legCmd),
      .hiGate  (highGate[g]),
      .loGate  (lowGate[g]),
      .loTurnOn(legTurnOn[g])
    );
  end

  assign loTurnOn = |legTurnOn;
endmodule

// File: rtl/pwmgd_ctrl.sv
module pwmgd_ctrl
  import pwmgd_pkg::*;
#(
  parameter int BLANK_CYC = 32,
  parameter int OFF_CYC   = 960
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         haltReq,
  input  logic         brakeReq,
  input  logic         faultIn,
  input  logic         ocTrip,
  input  logic         loTurnOn,
  output ctrlStrobes_t strobes
);
  localparam int OFF_W   = (OFF_CYC > 1) ? $clog2(OFF_CYC) : 1;
  localparam int BLANK_W = $clog2(BLANK_CYC + 1);

  driveMode_t         modeQ, modeNext;
  logic               recircQ;
  logic [OFF_W-1:0]   offCnt;
  logic [BLANK_W-1:0] blankCnt;
  logic               tripAccept;

  // fault beats halt beats brake
  always_comb begin
    if (faultIn || haltReq) modeNext = MODE_OFF;
    else if (brakeReq)      modeNext = MODE_BRAKE;
    else                    modeNext = MODE_RUN;
  end

  assign tripAccept = (modeQ == MODE_RUN) && !recircQ && ocTrip &&
                      (blankCnt == '0) && !loTurnOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_OFF;
      recircQ  <= 1'b0;
      offCnt   <= '0;
      blankCnt <= '0;
    end else begin
      modeQ <= modeNext;
      if (loTurnOn)            blankCnt <= BLANK_W'(BLANK_CYC);
      else if (blankCnt != '0) blankCnt <= blankCnt - 1'b1;

      if (recircQ) begin
        if (modeQ != MODE_RUN || offCnt == '0) recircQ <= 1'b0;
        else                                   offCnt  <= offCnt - 1'b1;
      end else if (tripAccept) begin
        recircQ <= 1'b1;
        offCnt  <= OFF_W'(OFF_CYC - 1);
      end
    end
  end

  always_comb begin
    strobes.pwmEn    = 1'b0;
    strobes.forceCmd = LEG_OFF;
    unique case (modeQ)
      MODE_BRAKE: strobes.forceCmd = LEG_LOW;
      MODE_RUN: begin
        if (recircQ) strobes.forceCmd = LEG_HIGH;
        else         strobes.pwmEn    = 1'b1;
      end
      default: strobes.forceCmd = LEG_OFF;
    endcase
  end
endmodule

// File: rtl/pwmgd_top.sv
module pwmgd_top
  import pwmgd_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int MOD_W      = 8,
  parameter int DEAD_CYC   = 64,
  parameter int BLANK_CYC  = 32,
  parameter int OFF_CYC    = 960
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      haltReq,
  input  logic                      brakeReq,
  input  logic                      faultIn,
  input  logic                      ocTrip,
  input  logic [NUM_LEGS*MOD_W-1:0] modWords,
  output logic [NUM_LEGS-1:0]       highGate,
  output logic [NUM_LEGS-1:0]       lowGate
);
  ctrlStrobes_t strobes;
  logic         loTurnOn;

  pwmgd_ctrl #(.BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .brakeReq(brakeReq),
    .faultIn(faultIn), .ocTrip(ocTrip), .loTurnOn(loTurnOn), .strobes(strobes)
  );

  pwmgd_datapath #(.PERIOD_CYC(PERIOD_CYC), .MOD_W(MOD_W), .DEAD_CYC(DEAD_CYC)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modWords(modWords),
    .highGate(highGate), .lowGate(lowGate), .loTurnOn(loTurnOn)
  );
endmodule

// File: rtl/pwmgd_checker.sv
module pwmgd_checker
  import pwmgd_pkg::*;
#(
  parameter int DEAD_CYC = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                haltReq,
  input logic                brakeReq,
  input logic                faultIn,
  input logic [NUM_LEGS-1:0] highGate,
  input logic [NUM_LEGS-1:0] lowGate
);
  localparam int OC_W = $clog2(DEAD_CYC + 1);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gChk
    logic [OC_W-1:0] offRun;
    always_ff @(posedge clk) begin
      if (!rstN)                                offRun <= '0;
      else if (highGate[g] || lowGate[g])       offRun <= '0;
      else if (offRun != OC_W'(DEAD_CYC))       offRun <= offRun + 1'b1;
    end

    assert_no_shoot_through_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(highGate[g] && lowGate[g]));

    assert_dead_gap_high_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(highGate[g]) |-> (offRun >= OC_W'(DEAD_CYC)));

    assert_dead_gap_low_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(lowGate[g]) |-> (offRun >= OC_W'(DEAD_CYC)));
  end

  assert_halt_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> ##2 (highGate == '0 && lowGate == '0));

  assert_fault_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |-> ##2 (highGate == '0 && lowGate == '0));

  assert_brake_no_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!haltReq && brakeReq && !faultIn) |-> ##2 (highGate == '0));
endmodule

bind pwmgd_top pwmgd_checker #(.DEAD_CYC(DEAD_CYC)) uChk (
  .clk(clk), .rstN(rstN), .haltReq(haltReq), .brakeReq(brakeReq),
  .faultIn(faultIn), .highGate(highGate), .lowGate(lowGate)
);

// File: tb/tb_pwmgd_top.sv
module tb_pwmgd_top;
  localparam int PERIOD = 2000;
  localparam int MODW   = 8;
  localparam int DEAD   = 64;
  localparam int BLANK  = 32;
  localparam int OFFT   = 960;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 1'b1, brakeReq = 1'b0, faultIn = 1'b0, ocTrip = 1'b0;
  logic [3*MODW-1:0] modWords = '0;
  logic [2:0] highGate, lowGate;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwmgd_top #(.PERIOD_CYC(PERIOD), .MOD_W(MODW), .DEAD_CYC(DEAD),
              .BLANK_CYC(BLANK), .OFF_CYC(OFFT)) dut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .brakeReq(brakeReq),
    .faultIn(faultIn), .ocTrip(ocTrip), .modWords(modWords),
    .highGate(highGate), .lowGate(lowGate)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int thrOf(input int m);
    return (m * PERIOD) >> MODW;
  endfunction

  task automatic tReset();
    waitCyc(4);
    check(highGate == 0 && lowGate == 0, "R5 reset", {highGate, lowGate}, 0);
    rstN = 1'b1;
    waitCyc(5);
    check(highGate == 0 && lowGate == 0, "R5 halted after reset", {highGate, lowGate}, 0);
  endtask

  task automatic tDuty();
    int mods[3] = '{64, 128, 200};
    int hiCnt[3];
    int loCnt[3];
    for (int i = 0; i < 3; i++) begin
      modWords[i*MODW +: MODW] = MODW'(mods[i]);
      hiCnt[i] = 0;
      loCnt[i] = 0;
    end
    haltReq = 1'b0;
    brakeReq = 1'b0;
    waitCyc(2*PERIOD + 10);
    for (int c = 0; c < PERIOD; c++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        hiCnt[i] += int'(highGate[i]);
        loCnt[i] += int'(lowGate[i]);
      end
    end
    for (int i = 0; i < 3; i++) begin
      check(hiCnt[i] == thrOf(mods[i]) - DEAD, "R1 high on-time", hiCnt[i], thrOf(mods[i]) - DEAD);
      check(loCnt[i] == PERIOD - thrOf(mods[i]) - DEAD, "R1 low on-time", loCnt[i],
            PERIOD - thrOf(mods[i]) - DEAD);
    end
  endtask

  task automatic tZeroAndFault();
    int bad = 0;
    modWords = '0;
    waitCyc(PERIOD + 10);
    for (int c = 0; c < PERIOD; c++) begin
      @(negedge clk);
      if (highGate != 3'b000 || lowGate != 3'b111) bad++;
    end
    check(bad == 0, "R4 zero word keeps low side on", bad, 0);
    faultIn = 1'b1;
    waitCyc(2);
    check(highGate == 0 && lowGate == 0, "R7 fault off", {highGate, lowGate}, 0);
    brakeReq = 1'b1;
    waitCyc(20);
    check(highGate == 0 && lowGate == 0, "R7 fault beats brake", {highGate, lowGate}, 0);
    brakeReq = 1'b0;
    faultIn = 1'b0;
    waitCyc(DEAD + 5);
    check(highGate == 3'b000 && lowGate == 3'b111, "R7 resumes after fault", {highGate, lowGate}, 7);
  endtask

  task automatic tHaltBrake();
    int bad = 0;
    modWords = {3{MODW'(128)}};
    waitCyc(PERIOD);
    brakeReq = 1'b1;
    haltReq = 1'b1;
    waitCyc(2);
    check(highGate == 0 && lowGate == 0, "R5 halt beats brake", {highGate, lowGate}, 0);
    haltReq = 1'b0;
    waitCyc(2);
    check(highGate == 3'b000, "R6 brake high sides off", highGate, 0);
    waitCyc(DEAD + 3);
    check(lowGate == 3'b111, "R6 brake low sides on", lowGate, 7);
    ocTrip = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (highGate != 3'b000 || lowGate != 3'b111) bad++;
    end
    ocTrip = 1'b0;
    check(bad == 0, "R10 trip ignored in brake", bad, 0);
  endtask

  task automatic tBlank();
    int bad = 0;
    int guard = 0;
    brakeReq = 1'b0;
    haltReq = 1'b1;
    modWords = '0;
    waitCyc(5);
    haltReq = 1'b0;
    while (!lowGate[0] && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    ocTrip = 1'b1;
    waitCyc(5);
    ocTrip = 1'b0;
    for (int c = 0; c < 150; c++) begin
      @(negedge clk);
      if (highGate != 3'b000 || lowGate != 3'b111) bad++;
    end
    check(bad == 0, "R9 trip in blanking ignored", bad, 0);
  endtask

  task automatic tTrip();
    int hiCnt[3];
    int overlap = 0;
    for (int i = 0; i < 3; i++) hiCnt[i] = 0;
    ocTrip = 1'b1;
    for (int c = 0; c < OFFT + DEAD + 200; c++) begin
      @(negedge clk);
      if (c == 9) ocTrip = 1'b0;
      for (int i = 0; i < 3; i++) hiCnt[i] += int'(highGate[i]);
      if ((highGate & lowGate) != 0) overlap++;
    end
    for (int i = 0; i < 3; i++)
      check(hiCnt[i] == OFFT - DEAD, "R8 recirculation high-side time", hiCnt[i], OFFT - DEAD);
    check(overlap == 0, "R2 no overlap during trip", overlap, 0);
    check(highGate == 3'b000 && lowGate == 3'b111, "R8 carrier drive resumes", {highGate, lowGate}, 7);
  endtask

  initial begin
    tReset();
    tDuty();
    tZeroAndFault();
    tHaltBrake();
    tBlank();
    tTrip();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule